// File: doc/BRIEF.md
# Time-Sliced Logic Self-Test Controller

This block runs a logic self-test in several short slices instead of one long session. Each slice is placed in an idle gap of the functional operation, for example the pause between two video frames. During a slice the controller shifts pseudo-random patterns from an on-chip generator into a set of scan chains and pulses the capture cycles. It folds every unloaded chain bit into a multiple-input signature register. At the end of the slice it compares the intermediate signature with the value software programmed for that slice.

The controller keeps track of which slice comes next. At the end of every completed slice it saves the generator state and the signature state. The next slice resumes from those saved values, so it produces exactly the patterns that belong to it, and the chain of slices gives the same signatures as one uninterrupted run. If the idle window closes in the middle of a slice, the slice is abandoned and is repeated at the next opportunity.

A small word-addressed register interface sets the slice count and the number of patterns per slice, holds one expected signature for each slice, and reports a pass bit and a fail bit for each slice. It also exposes the last intermediate signature and the next slice index. The circuit under test and its scan chains are outside the block.

Top module: `lbist_slice_ctrl`

## Requirements
- R1: After reset the block is idle and drives `scan_clock_en` and `scan_enable` low. Register reads give: status 0, signature 0, next slice index 0, done 0, slice field 3 (all four slices) and pattern field 4.
- R2: A slice begins only on a clock where `slice_start` and `idle_window` are both high and the last slice has not yet completed. A start pulse in any other condition leaves the block idle and issues no scan clock.
- R3: Each pattern takes CHAIN_LEN cycles with `scan_clock_en`=1 and `scan_enable`=1, then one capture cycle with `scan_clock_en`=1 and `scan_enable`=0. A slice of P patterns ends with CHAIN_LEN further flush shift cycles in which `scan_si` is held at 0. A complete slice therefore has P*(CHAIN_LEN+1)+CHAIN_LEN scan clock cycles and P capture cycles.
- R4: The pattern generator is a right-shifting Galois LFSR: next = (s>>1) XOR (s[0] ? 0xB400 : 0), with seed 0xACE1. Chain c receives generator bit c on every shift cycle of a pattern, and the generator advances once per such cycle.
- R5: The signature register updates as next = (m>>1) XOR (m[0] ? 0xD008 : 0) XOR scan_so, where scan_so is zero-extended and chain c enters bit c. It starts at 0 and updates on every shift cycle except those of the first pattern of a slice, whose unload is stale. The flush cycles are included.
- R6: Each slice starts from the generator and signature states saved at the end of the previous completed slice. A sequence of slices therefore yields the same per-slice signatures as one continuous run.
- R7: When a slice completes, the slice's pass bit (status bit k) is set if the signature equals the expected register at word 4+k; otherwise its fail bit (status bit 16+k) is set. The final signature is latched into the signature register at word 3, and the next slice index advances. A failing slice still saves its state and advances.
- R8: If `idle_window` is low during a shift, capture or flush cycle, no scan clock is issued in that cycle and the block returns to idle. The saved states, the status and the slice index stay unchanged, so the same slice is rerun on the next start.
- R9: When the last configured slice completes with a pass, done (control word 0 bit 1) is set. Once the last slice has completed, whether it passed or failed, further start pulses are ignored until a restart.
- R10: Writing 1 to control bit 0 restarts the test. It returns the slice index to 0, clears the status, done and signature registers, reseeds the saved generator state to 0xACE1, clears the saved signature state to 0, and abandons any running slice.
- R11: Configuration word 1 holds the index of the last slice to run in bits [1:0] and the patterns per slice in bits [23:16]. A pattern count of 0 behaves as 1. Control word 0 reads busy in bit 0, done in bit 1 and the next slice index in bits [9:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_start | input | 1 | Request to run the next slice |
| idle_window | input | 1 | High while the functional logic leaves the chains free |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| scan_enable | output | 1 | High for shift, low for capture |
| scan_clock_en | output | 1 | Clock enable for the scan flops of the circuit under test |
| scan_si | output | NUM_CHAINS | Serial input of each chain |
| scan_so | input | NUM_CHAINS | Serial output of each chain |
| busy | output | 1 | A slice is in progress |
| done | output | 1 | The last slice has completed with a pass |

## Verification
A wrong generator or signature state does not show at once. It appears at the next slice boundary as a pass or fail bit that differs from the bench's own continuous-run model, and as a latched signature that differs from the model's value. A miscounted shift or capture appears within one slice as a wrong scan clock or capture count, and soon after as a signature mismatch. Errors in the abort and resume path show when a slice is rerun after an interrupted attempt: if any state leaked, the rerun signature no longer matches the uninterrupted model.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPTURE,
        ST_FLUSH,
        ST_CHECK
    } seq_state_e;

    // word addresses of the register interface
    localparam int REG_CTRL     = 0;
    localparam int REG_CFG      = 1;
    localparam int REG_STATUS   = 2;
    localparam int REG_SIG      = 3;
    localparam int REG_EXP_BASE = 4;

    // field positions
    localparam int CTRL_IDX_LSB  = 8;
    localparam int CFG_PAT_LSB   = 16;
    localparam int STAT_FAIL_LSB = 16;

endpackage

// File: rtl/lbist_lfsr.sv
module lbist_lfsr #(
    parameter int           W       = 16,
    parameter logic [W-1:0] TAPS    = 16'hB400,
    parameter logic [W-1:0] SEED    = 16'hACE1,
    parameter int           IN_W    = 1,
    parameter bit           NONZERO = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [W-1:0]    load_val,
    input  logic            step,
    input  logic [IN_W-1:0] din,
    output logic [W-1:0]    state
);

    typedef struct packed {
        logic [W-1:0] val;
    } lfsr_t;

    lfsr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.val = load_val;
        end else if (step) begin
            s_d.val = {1'b0, s_q.val[W-1:1]} ^ (s_q.val[0] ? TAPS : '0) ^ W'(din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.val <= SEED;
        end else begin
            s_q <= s_d;
        end
    end

    assign state = s_q.val;

    generate
        if (NONZERO) begin : g_nonzero
            AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.val != '0); // R4
        end
    endgenerate

endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
    import lbist_pkg::*;
#(
    parameter int                CHAIN_LEN  = 8,
    parameter int                NUM_SLICES = 4,
    parameter int                PAT_W      = 8,
    parameter int                PRPG_W     = 16,
    parameter int                MISR_W     = 16,
    parameter logic [PRPG_W-1:0] PRPG_SEED  = 16'hACE1,
    parameter logic [MISR_W-1:0] MISR_SEED  = '0,
    localparam int               BIT_W      = $clog2(CHAIN_LEN),
    localparam int               SLICE_W    = $clog2(NUM_SLICES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               window,
    input  logic               restart,
    input  logic [SLICE_W-1:0] cfg_last,
    input  logic [PAT_W-1:0]   cfg_pat,
    input  logic [PRPG_W-1:0]  prpg_cur,
    input  logic [MISR_W-1:0]  misr_cur,
    input  logic               cmp_pass,
    output logic               scan_en,
    output logic               clk_en,
    output logic               flush,
    output logic               prpg_load,
    output logic               prpg_step,
    output logic               misr_load,
    output logic               misr_step,
    output logic [PRPG_W-1:0]  saved_prpg,
    output logic [MISR_W-1:0]  saved_misr,
    output logic               slice_end,
    output logic [SLICE_W-1:0] slice_idx,
    output logic               busy,
    output logic               done
);

    typedef struct packed {
        seq_state_e         st;
        logic [BIT_W-1:0]   bitc;
        logic [PAT_W-1:0]   pat;
        logic [SLICE_W-1:0] slice;
        logic               first;
        logic               fin;
        logic               done;
        logic [PRPG_W-1:0]  sv_prpg;
        logic [MISR_W-1:0]  sv_misr;
    } seq_t;

    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CHAIN_LEN - 1);

    seq_t q, d;
    logic [PAT_W-1:0] pat_last;

    // a pattern count of zero behaves as one
    assign pat_last = (cfg_pat == '0) ? '0 : cfg_pat - 1'b1;

    always_comb begin
        d         = q;
        scan_en   = 1'b0;
        clk_en    = 1'b0;
        flush     = 1'b0;
        prpg_load = 1'b0;
        prpg_step = 1'b0;
        misr_load = 1'b0;
        misr_step = 1'b0;
        slice_end = 1'b0;
        if (restart) begin
            d.st      = ST_IDLE;
            d.slice   = '0;
            d.fin     = 1'b0;
            d.done    = 1'b0;
            d.sv_prpg = PRPG_SEED;
            d.sv_misr = MISR_SEED;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (start && window && !q.fin) begin
                        prpg_load = 1'b1;
                        misr_load = 1'b1;
                        d.st      = ST_SHIFT;
                        d.bitc    = '0;
                        d.pat     = '0;
                        d.first   = 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (!window) begin
                        d.st = ST_IDLE;
                    end else begin
                        scan_en   = 1'b1;
                        clk_en    = 1'b1;
                        prpg_step = 1'b1;
                        misr_step = !q.first;
                        d.bitc    = q.bitc + 1'b1;
                        if (q.bitc == BIT_LAST) begin
                            d.bitc = '0;
                            d.st   = ST_CAPTURE;
                        end
                    end
                end
                ST_CAPTURE: begin
                    if (!window) begin
                        d.st = ST_IDLE;
                    end else begin
                        clk_en  = 1'b1;
                        d.first = 1'b0;
                        if (q.pat == pat_last) begin
                            d.st = ST_FLUSH;
                        end else begin
                            d.pat = q.pat + 1'b1;
                            d.st  = ST_SHIFT;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (!window) begin
                        d.st = ST_IDLE;
                    end else begin
                        scan_en   = 1'b1;
                        clk_en    = 1'b1;
                        flush     = 1'b1;
                        misr_step = 1'b1;
                        d.bitc    = q.bitc + 1'b1;
                        if (q.bitc == BIT_LAST) begin
                            d.bitc = '0;
                            d.st   = ST_CHECK;
                        end
                    end
                end
                ST_CHECK: begin
                    slice_end = 1'b1;
                    d.sv_prpg = prpg_cur;
                    d.sv_misr = misr_cur;
                    d.st      = ST_IDLE;
                    if (q.slice >= cfg_last) begin
                        d.fin  = 1'b1;
                        d.done = cmp_pass;
                    end else begin
                        d.slice = q.slice + 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.bitc    <= '0;
            q.pat     <= '0;
            q.slice   <= '0;
            q.first   <= 1'b0;
            q.fin     <= 1'b0;
            q.done    <= 1'b0;
            q.sv_prpg <= PRPG_SEED;
            q.sv_misr <= MISR_SEED;
        end else begin
            q <= d;
        end
    end

    assign saved_prpg = q.sv_prpg;
    assign saved_misr = q.sv_misr;
    assign slice_idx  = q.slice;
    assign busy       = (q.st != ST_IDLE);
    assign done       = q.done;

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st inside {ST_SHIFT, ST_CAPTURE, ST_FLUSH}) && !window |=> q.st == ST_IDLE); // R8

    AST_CAPTURE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_CAPTURE |-> $past(q.st) == ST_SHIFT); // R3

    AST_SAVE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sv_prpg) |-> ($past(q.st) == ST_CHECK || $past(restart))); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.done && !restart |=> q.done); // R9

    AST_NO_START_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        q.fin && q.st == ST_IDLE && !restart |=> q.st == ST_IDLE); // R9

endmodule

// File: rtl/lbist_regs.sv
module lbist_regs
    import lbist_pkg::*;
#(
    parameter int  NUM_SLICES = 4,
    parameter int  MISR_W     = 16,
    parameter int  PAT_W      = 8,
    parameter int  DEF_PAT    = 4,
    parameter int  DATA_W     = 32,
    localparam int SLICE_W    = $clog2(NUM_SLICES),
    localparam int ADDR_W     = $clog2(REG_EXP_BASE + NUM_SLICES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               restart,
    output logic [SLICE_W-1:0] cfg_last,
    output logic [PAT_W-1:0]   cfg_pat,
    input  logic               slice_end,
    input  logic [SLICE_W-1:0] slice_idx,
    input  logic [MISR_W-1:0]  misr_cur,
    input  logic               busy,
    input  logic               done,
    output logic               cmp_pass
);

    typedef struct packed {
        logic [NUM_SLICES-1:0][MISR_W-1:0] exp;
        logic [NUM_SLICES-1:0]             pass;
        logic [NUM_SLICES-1:0]             fail;
        logic [SLICE_W-1:0]                last;
        logic [PAT_W-1:0]                  pat;
        logic [MISR_W-1:0]                 sig;
    } regs_t;

    regs_t q, d;
    logic  wdata_unused;

    assign wdata_unused = ^bus_wdata;
    assign restart      = bus_we && (bus_addr == ADDR_W'(REG_CTRL)) && bus_wdata[0];
    assign cmp_pass     = (misr_cur == q.exp[slice_idx]);

    always_comb begin
        d = q;
        if (bus_we) begin
            if (bus_addr == ADDR_W'(REG_CFG)) begin
                d.last = bus_wdata[SLICE_W-1:0];
                d.pat  = bus_wdata[CFG_PAT_LSB +: PAT_W];
            end
            for (int i = 0; i < NUM_SLICES; i++) begin
                if (bus_addr == ADDR_W'(REG_EXP_BASE + i)) begin
                    d.exp[i] = bus_wdata[MISR_W-1:0];
                end
            end
        end
        if (restart) begin
            d.pass = '0;
            d.fail = '0;
            d.sig  = '0;
        end else if (slice_end) begin
            if (cmp_pass) begin
                d.pass[slice_idx] = 1'b1;
            end else begin
                d.fail[slice_idx] = 1'b1;
            end
            d.sig = misr_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.exp  <= '0;
            q.pass <= '0;
            q.fail <= '0;
            q.last <= SLICE_W'(NUM_SLICES - 1);
            q.pat  <= PAT_W'(DEF_PAT);
            q.sig  <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_CTRL)) begin
            bus_rdata[0]                          = busy;
            bus_rdata[1]                          = done;
            bus_rdata[CTRL_IDX_LSB +: SLICE_W]    = slice_idx;
        end else if (bus_addr == ADDR_W'(REG_CFG)) begin
            bus_rdata[SLICE_W-1:0]                = q.last;
            bus_rdata[CFG_PAT_LSB +: PAT_W]       = q.pat;
        end else if (bus_addr == ADDR_W'(REG_STATUS)) begin
            bus_rdata[NUM_SLICES-1:0]             = q.pass;
            bus_rdata[STAT_FAIL_LSB +: NUM_SLICES] = q.fail;
        end else if (bus_addr == ADDR_W'(REG_SIG)) begin
            bus_rdata[MISR_W-1:0]                 = q.sig;
        end
        for (int i = 0; i < NUM_SLICES; i++) begin
            if (bus_addr == ADDR_W'(REG_EXP_BASE + i)) begin
                bus_rdata[MISR_W-1:0] = q.exp[i];
            end
        end
    end

    assign cfg_last = q.last;
    assign cfg_pat  = q.pat;

    AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pass & q.fail) == '0); // R7

    AST_VERDICT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        slice_end && !restart |=> (q.pass[$past(slice_idx)] | q.fail[$past(slice_idx)])); // R7

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (q.pass == '0 && q.fail == '0 && q.sig == '0)); // R10

endmodule

// File: rtl/lbist_slice_ctrl.sv
module lbist_slice_ctrl
    import lbist_pkg::*;
#(
    parameter int                NUM_CHAINS = 4,
    parameter int                CHAIN_LEN  = 8,
    parameter int                NUM_SLICES = 4,
    parameter int                PAT_W      = 8,
    parameter int                DEF_PAT    = 4,
    parameter int                PRPG_W     = 16,
    parameter int                MISR_W     = 16,
    parameter logic [PRPG_W-1:0] PRPG_TAPS  = 16'hB400,
    parameter logic [PRPG_W-1:0] PRPG_SEED  = 16'hACE1,
    parameter logic [MISR_W-1:0] MISR_TAPS  = 16'hD008,
    localparam int               DATA_W     = 32,
    localparam int               ADDR_W     = $clog2(REG_EXP_BASE + NUM_SLICES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  slice_start,
    input  logic                  idle_window,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  scan_enable,
    output logic                  scan_clock_en,
    output logic [NUM_CHAINS-1:0] scan_si,
    input  logic [NUM_CHAINS-1:0] scan_so,
    output logic                  busy,
    output logic                  done
);

    localparam int               SLICE_W   = $clog2(NUM_SLICES);
    localparam logic [MISR_W-1:0] MISR_SEED = '0;

    logic               restart;
    logic [SLICE_W-1:0] cfg_last;
    logic [PAT_W-1:0]   cfg_pat;
    logic [PRPG_W-1:0]  prpg_state, saved_prpg;
    logic [MISR_W-1:0]  misr_state, saved_misr;
    logic               prpg_load, prpg_step, misr_load, misr_step;
    logic               flush, slice_end, cmp_pass;
    logic [SLICE_W-1:0] slice_idx;

    lbist_lfsr #(
        .W       (PRPG_W),
        .TAPS    (PRPG_TAPS),
        .SEED    (PRPG_SEED),
        .IN_W    (1),
        .NONZERO (1'b1)
    ) i_prpg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (prpg_load),
        .load_val (saved_prpg),
        .step     (prpg_step),
        .din      (1'b0),
        .state    (prpg_state)
    );

    lbist_lfsr #(
        .W       (MISR_W),
        .TAPS    (MISR_TAPS),
        .SEED    (MISR_SEED),
        .IN_W    (NUM_CHAINS),
        .NONZERO (1'b0)
    ) i_misr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (misr_load),
        .load_val (saved_misr),
        .step     (misr_step),
        .din      (scan_so),
        .state    (misr_state)
    );

    lbist_seq #(
        .CHAIN_LEN  (CHAIN_LEN),
        .NUM_SLICES (NUM_SLICES),
        .PAT_W      (PAT_W),
        .PRPG_W     (PRPG_W),
        .MISR_W     (MISR_W),
        .PRPG_SEED  (PRPG_SEED),
        .MISR_SEED  (MISR_SEED)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (slice_start),
        .window     (idle_window),
        .restart    (restart),
        .cfg_last   (cfg_last),
        .cfg_pat    (cfg_pat),
        .prpg_cur   (prpg_state),
        .misr_cur   (misr_state),
        .cmp_pass   (cmp_pass),
        .scan_en    (scan_enable),
        .clk_en     (scan_clock_en),
        .flush      (flush),
        .prpg_load  (prpg_load),
        .prpg_step  (prpg_step),
        .misr_load  (misr_load),
        .misr_step  (misr_step),
        .saved_prpg (saved_prpg),
        .saved_misr (saved_misr),
        .slice_end  (slice_end),
        .slice_idx  (slice_idx),
        .busy       (busy),
        .done       (done)
    );

    lbist_regs #(
        .NUM_SLICES (NUM_SLICES),
        .MISR_W     (MISR_W),
        .PAT_W      (PAT_W),
        .DEF_PAT    (DEF_PAT),
        .DATA_W     (DATA_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .restart   (restart),
        .cfg_last  (cfg_last),
        .cfg_pat   (cfg_pat),
        .slice_end (slice_end),
        .slice_idx (slice_idx),
        .misr_cur  (misr_state),
        .busy      (busy),
        .done      (done),
        .cmp_pass  (cmp_pass)
    );

    assign scan_si = flush ? '0 : prpg_state[NUM_CHAINS-1:0];

    AST_CLOCK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        scan_clock_en |-> idle_window); // R8

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        scan_clock_en && scan_enable && !prpg_step |-> scan_si == '0); // R3

endmodule

// File: tb/test_lbist_slice_ctrl.sv
module test_lbist_slice_ctrl;

    localparam int NC = 4;
    localparam int CL = 8;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slice_start = 1'b0;
    logic        idle_window = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        scan_enable, scan_clock_en, busy, done;
    logic [NC-1:0] scan_si, scan_so;

    int checks = 0;
    int failures = 0;
    int clk_cnt = 0;
    int cap_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lbist_slice_ctrl i_lbist_slice_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .slice_start   (slice_start),
        .idle_window   (idle_window),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .scan_enable   (scan_enable),
        .scan_clock_en (scan_clock_en),
        .scan_si       (scan_si),
        .scan_so       (scan_so),
        .busy          (busy),
        .done          (done)
    );

    // ---------------- circuit under test model ----------------
    function automatic logic [NC*CL-1:0] cut_shift(input logic [NC*CL-1:0] v, input logic [NC-1:0] si);
        logic [NC*CL-1:0] r;
        for (int c = 0; c < NC; c++) r[c*CL +: CL] = {v[c*CL +: CL-1], si[c]};
        return r;
    endfunction

    function automatic logic [NC*CL-1:0] cut_capture(input logic [NC*CL-1:0] v);
        logic [NC*CL-1:0] r;
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < CL; i++)
                r[c*CL+i] = v[c*CL+i] ^ v[((c+1)%NC)*CL + (i+1)%CL]
                          ^ (v[((c+2)%NC)*CL + i] & v[c*CL + (i+CL-1)%CL]);
        return r;
    endfunction

    function automatic logic [NC-1:0] cut_out(input logic [NC*CL-1:0] v);
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++) r[c] = v[c*CL + CL-1];
        return r;
    endfunction

    logic [NC*CL-1:0] cut_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cut_q <= '0;
        else if (scan_clock_en) cut_q <= scan_enable ? cut_shift(cut_q, scan_si) : cut_capture(cut_q);
    end
    assign scan_so = cut_out(cut_q);

    always @(posedge clk) begin
        if (scan_clock_en) clk_cnt <= clk_cnt + 1;
        if (scan_clock_en && !scan_enable) cap_cnt <= cap_cnt + 1;
    end

    // ---------------- reference model ----------------
    function automatic logic [15:0] gen_step(input logic [15:0] s);
        return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic logic [15:0] sig_step(input logic [15:0] m, input logic [NC-1:0] d);
        return {1'b0, m[15:1]} ^ (m[0] ? 16'hD008 : 16'h0000) ^ 16'(d);
    endfunction

    function automatic void ref_slice(input int pats, inout logic [15:0] s, inout logic [15:0] m);
        logic [NC*CL-1:0] v = '0;
        for (int p = 0; p < pats; p++) begin
            for (int b = 0; b < CL; b++) begin
                if (p > 0) m = sig_step(m, cut_out(v));
                v = cut_shift(v, s[NC-1:0]);
                s = gen_step(s);
            end
            v = cut_capture(v);
        end
        for (int b = 0; b < CL; b++) begin
            m = sig_step(m, cut_out(v));
            v = cut_shift(v, '0);
        end
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'(addr); bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input int addr, output logic [31:0] data);
        bus_addr = 3'(addr);
        #1;
        data = bus_rdata;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        clk_cnt = 0; cap_cnt = 0;
        slice_start = 1'b1;
        @(negedge clk);
        slice_start = 1'b0;
    endtask

    task automatic run_slice();
        pulse_start();
        while (busy) @(negedge clk);
    endtask

    logic [15:0] exp_sig [NS];

    task automatic compute_all(input int pats, input int last, input logic [15:0] s0, input logic [15:0] m0);
        logic [15:0] s = s0;
        logic [15:0] m = m0;
        for (int k = 0; k <= last; k++) begin
            ref_slice(pats, s, m);
            exp_sig[k] = m;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int pats, last, effp;
        void'($urandom(32'd7151));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!busy && !done && !scan_clock_en && !scan_enable, "R1", "idle outputs",
              {busy, done, scan_clock_en, scan_enable}, 0);
        bus_read(2, rd); check(rd == 0, "R1", "status", rd, 0);
        bus_read(3, rd); check(rd == 0, "R1", "signature", rd, 0);
        bus_read(0, rd); check(rd == 0, "R1", "control", rd, 0);
        bus_read(1, rd); check(rd == 32'h0004_0003, "R1 R11", "config", rd, 32'h0004_0003);

        // directed run: 4 slices of 5 patterns, slice 2 programmed wrong
        bus_write(1, (32'd5 << 16) | 32'd3);
        compute_all(5, 3, 16'hACE1, 16'h0000);
        for (int k = 0; k < NS; k++)
            bus_write(4 + k, 32'(exp_sig[k] ^ ((k == 2) ? 16'h0001 : 16'h0000)));

        // R2 start outside window is ignored
        idle_window = 1'b0;
        pulse_start();
        repeat (3) @(negedge clk);
        check(!busy && clk_cnt == 0, "R2", "start without window", clk_cnt, 0);
        idle_window = 1'b1;

        // slice 0
        run_slice();
        check(clk_cnt == 5*(CL+1)+CL, "R3", "scan clocks per slice", clk_cnt, 5*(CL+1)+CL);
        check(cap_cnt == 5, "R3", "captures per slice", cap_cnt, 5);
        bus_read(3, rd); check(rd[15:0] == exp_sig[0], "R4 R5", "slice0 signature", rd, exp_sig[0]);
        bus_read(2, rd); check(rd == 32'h1, "R7", "slice0 pass", rd, 32'h1);
        bus_read(0, rd); check(rd[9:8] == 2'd1, "R7 R11", "index after slice0", rd[9:8], 1);

        // R8 abort mid slice 1
        pulse_start();
        repeat (6) @(negedge clk);
        idle_window = 1'b0;
        @(negedge clk);
        check(!busy && !scan_clock_en, "R8", "abort returns idle", {busy, scan_clock_en}, 0);
        bus_read(2, rd); check(rd == 32'h1, "R8", "status untouched", rd, 32'h1);
        bus_read(0, rd); check(rd[9:8] == 2'd1, "R8", "index untouched", rd[9:8], 1);
        bus_read(3, rd); check(rd[15:0] == exp_sig[0], "R8", "signature untouched", rd, exp_sig[0]);
        idle_window = 1'b1;

        // R6 rerun slice 1 resumes from saved state
        run_slice();
        bus_read(3, rd); check(rd[15:0] == exp_sig[1], "R6", "slice1 signature after abort", rd, exp_sig[1]);
        bus_read(2, rd); check(rd == 32'h3, "R6", "slice1 pass", rd, 32'h3);

        // R7 failing slice still advances
        run_slice();
        bus_read(2, rd); check(rd == 32'h0004_0003, "R7", "slice2 fail bit", rd, 32'h0004_0003);
        bus_read(0, rd); check(rd[9:8] == 2'd3 && !done, "R7", "index after fail", rd, 32'h300);

        // R9 last slice passes -> done
        run_slice();
        bus_read(3, rd); check(rd[15:0] == exp_sig[3], "R6", "slice3 signature", rd, exp_sig[3]);
        check(done == 1'b1, "R9", "done after last pass", done, 1);
        bus_read(2, rd); check(rd == 32'h0004_000B, "R9", "final status", rd, 32'h0004_000B);
        pulse_start();
        repeat (3) @(negedge clk);
        check(!busy && clk_cnt == 0 && done, "R9", "start after end ignored", clk_cnt, 0);

        // R10 restart
        bus_write(0, 32'h1);
        bus_read(2, rd); check(rd == 0, "R10", "status cleared", rd, 0);
        bus_read(3, rd); check(rd == 0, "R10", "signature cleared", rd, 0);
        bus_read(0, rd); check(rd == 0, "R10", "control cleared", rd, 0);

        // R4 generator bits on the chains from the reseeded state
        pulse_start();
        check(scan_enable && scan_si == 4'h1, "R4", "first shift bits", scan_si, 4'h1);
        @(negedge clk);
        check(scan_si == gen_step(16'hACE1)[3:0], "R4", "second shift bits",
              scan_si, gen_step(16'hACE1)[3:0]);
        idle_window = 1'b0;
        @(negedge clk);
        idle_window = 1'b1;

        // random configurations, each from a fresh restart
        for (int t = 0; t < 3; t++) begin
            pats = (t == 0) ? 0 : 1 + int'($urandom % 6);
            last = (t == 0) ? 1 : int'($urandom % 4);
            effp = (pats == 0) ? 1 : pats;
            bus_write(0, 32'h1);
            bus_write(1, (32'(pats) << 16) | 32'(last));
            compute_all(effp, last, 16'hACE1, 16'h0000);
            for (int k = 0; k <= last; k++) bus_write(4 + k, 32'(exp_sig[k]));
            for (int k = 0; k <= last; k++) begin
                run_slice();
                check(clk_cnt == effp*(CL+1)+CL, "R11", "scan clocks for pattern field",
                      clk_cnt, effp*(CL+1)+CL);
                bus_read(3, rd); check(rd[15:0] == exp_sig[k], "R6", "random slice signature", rd, exp_sig[k]);
            end
            bus_read(2, rd);
            check(rd == ((32'h1 << (last+1)) - 1), "R7", "random pass mask", rd, (32'h1 << (last+1)) - 1);
            check(done == 1'b1, "R9", "done after random run", done, 1);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule